// File: doc/BRIEF.md
# TDM Time Slot Interchange Core

This core moves 8-bit time slots between a set of serial TDM input streams and the same number of serial output streams. Every input stream is deserialized, and each completed byte is stored in a data memory indexed by stream and by a channel counter. The frame pulse restarts that counter. For every output stream and channel, a 16-bit connection word sets the byte to transmit. In connection mode, the word names a source input stream and channel. In processor mode, the word carries the byte itself.

The data memory holds two banks, selected by frame parity. Reads always come from the frame that last completed, while the current frame is being written into the other bank. Each output is presented as a data bit plus an enable bit. An enable of zero stands for a high-impedance driver.

The connection word also carries a per-channel output enable and a loopback flag. Two master enables gate every channel: an external drive-enable input and a standby bit in the control register. A flat host port, decoded combinationally, reads and writes the control register and the connection memory, and reads the data memory.

Top module: `tsi_core`

## Requirements
- R1: While reset is low, and until the first host write after it, every `txEn` bit is 0. The control register and every connection word read back as 0.
- R2: Each bit lasts CLKS_PER_BIT clock cycles, and a channel is 8 bits sent MSB first. Channel 0, bit 7 starts in the cycle after the clock edge that samples `framePulse` high, from any counter position. An input bit is sampled at the last clock of its bit cell.
- R3: A connection word with bit 15 = 0 sends, on its output stream and channel, the input byte from the stream given by bits [CH_W+ST_W-1:CH_W] and the channel given by bits [CH_W-1:0]. That byte is taken from the previous complete frame.
- R4: Any number of output channels may name the same source, and each of them carries that source's byte.
- R5: A connection word with bit 15 = 1 sends its bits [7:0] in every frame.
- R6: Bit 13 of a connection word is the channel output enable. When it is 0, `txEn` and `txData` for that stream stay 0 for all 8 bits of that channel only.
- R7: When `outDriveEn` is 0, every `txEn` and `txData` bit is 0.
- R8: Control register bit 0 is the standby enable. When it is 0, every `txEn` and `txData` bit is 0.
- R9: When bit 12 of the connection word for output stream n, channel m is 1, the bit sent on that channel replaces `rxIn[n]` as the input for stream n, channel m.
- R10: Address bits [ADDR_W-1:ADDR_W-2] select the target: 0 = control register, 1 = connection memory, 2 = data memory (read-only; reads return {8'h00, byte} from the last completed frame), 3 = reads 0. The low bits hold {stream, channel}. A written connection word reads back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, CLKS_PER_BIT cycles per serial bit |
| rstN | input | 1 | Asynchronous active-low reset |
| framePulse | input | 1 | Frame boundary marker, one clock wide |
| outDriveEn | input | 1 | External master output enable |
| rxIn | input | STREAMS | Serial input streams |
| txData | output | STREAMS | Serial output data, 0 while disabled |
| txEn | output | STREAMS | Per-stream output driver enable |
| hostWr | input | 1 | Host write strobe |
| hostAddr | input | ADDR_W | Host address {region, stream, channel} |
| hostWrData | input | 16 | Host write data |
| hostRdData | output | 16 | Host read data for `hostAddr` |

## Verification
The bench builds the core with STREAMS = 4, CHANNELS = 32 and CLKS_PER_BIT = 2. One frame is then 512 clocks, so two-frame runs stay short. A full-length frame still exercises the channel wrap at 31, the bank swap at the frame pulse, and source selection across every stream. Four streams make it possible to test broadcast, processor-sourced channels, disabled channels and a loopback channel together within one frame, with each mode on a different stream.

// File: rtl/tsi_pkg.sv
package tsi_pkg;

  // connection word control bit positions
  localparam int BIT_PROC = 15;
  localparam int BIT_DLY  = 14;
  localparam int BIT_OE   = 13;
  localparam int BIT_LOOP = 12;

  // host address regions
  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_CONN = 2'd1;
  localparam logic [1:0] REG_DATA = 2'd2;

  typedef struct packed {
    logic sampleBit;  // last clock of a bit cell
    logic byteDone;   // last clock of bit 7 of a channel
    logic bank;       // data memory bank being written
    logic connWr;     // host writes a connection word
    logic globalEn;   // both master enables active
  } tsiStrobe_t;

endpackage

// File: rtl/tsi_ctrl.sv
module tsi_ctrl
  import tsi_pkg::*;
#(
  parameter int STREAMS      = 4,
  parameter int CHANNELS     = 32,
  parameter int CLKS_PER_BIT = 2
) (
  input  logic                                                  clk,
  input  logic                                                  rstN,
  input  logic                                                  framePulse,
  input  logic                                                  outDriveEn,
  input  logic                                                  hostWr,
  input  logic [2+$clog2(STREAMS)+$clog2(CHANNELS)-1:0]         hostAddr,
  input  logic                                                  standbyWrBit,
  input  logic [15:0]                                           connRdWord,
  input  logic [7:0]                                            dataRdByte,
  output tsiStrobe_t                                            strobe,
  output logic [$clog2(CHANNELS)-1:0]                           chan,
  output logic [2:0]                                            bitIdx,
  output logic [$clog2(STREAMS)-1:0]                            hostStream,
  output logic [$clog2(CHANNELS)-1:0]                           hostChan,
  output logic [15:0]                                           hostRdData
);

  localparam int ST_W   = $clog2(STREAMS);
  localparam int CH_W   = $clog2(CHANNELS);
  localparam int ADDR_W = 2 + ST_W + CH_W;
  localparam int PH_W   = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;

  logic [PH_W-1:0] phase;
  logic [2:0]      bitCnt;
  logic [CH_W-1:0] chanCnt;
  logic            bankReg;
  logic            standbyReg;
  logic [1:0]      region;
  logic            lastPhase;

  assign region     = hostAddr[ADDR_W-1 -: 2];
  assign hostStream = hostAddr[CH_W +: ST_W];
  assign hostChan   = hostAddr[CH_W-1:0];
  assign lastPhase  = (phase == PH_W'(CLKS_PER_BIT - 1));
  assign chan       = chanCnt;
  assign bitIdx     = bitCnt;

  // bit / channel / frame timing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= '0;
      bitCnt  <= '0;
      chanCnt <= '0;
      bankReg <= 1'b0;
    end else if (framePulse) begin
      phase   <= '0;
      bitCnt  <= '0;
      chanCnt <= '0;
      bankReg <= ~bankReg;
    end else if (lastPhase) begin
      phase  <= '0;
      bitCnt <= bitCnt + 3'd1;
      if (bitCnt == 3'd7) begin
        if (chanCnt == CH_W'(CHANNELS - 1)) chanCnt <= '0;
        else                                chanCnt <= chanCnt + CH_W'(1);
      end
    end else begin
      phase <= phase + PH_W'(1);
    end
  end

  // control register: standby enable
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            standbyReg <= 1'b0;
    else if (hostWr && region == REG_CTRL) standbyReg <= standbyWrBit;
  end

  always_comb begin
    strobe.sampleBit = lastPhase;
    strobe.byteDone  = lastPhase && (bitCnt == 3'd7);
    strobe.bank      = bankReg;
    strobe.connWr    = hostWr && (region == REG_CONN);
    strobe.globalEn  = standbyReg && outDriveEn;
  end

  always_comb begin
    unique case (region)
      REG_CTRL: hostRdData = {15'd0, standbyReg};
      REG_CONN: hostRdData = connRdWord;
      REG_DATA: hostRdData = {8'd0, dataRdByte};
      default:  hostRdData = 16'd0;
    endcase
  end

endmodule

// File: rtl/tsi_datapath.sv
module tsi_datapath
  import tsi_pkg::*;
#(
  parameter int STREAMS  = 4,
  parameter int CHANNELS = 32
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  tsiStrobe_t                  strobe,
  input  logic [$clog2(CHANNELS)-1:0] chan,
  input  logic [2:0]                  bitIdx,
  input  logic [$clog2(STREAMS)-1:0]  hostStream,
  input  logic [$clog2(CHANNELS)-1:0] hostChan,
  input  logic [15:0]                 hostWrData,
  input  logic [STREAMS-1:0]          rxIn,
  output logic [STREAMS-1:0]          txData,
  output logic [STREAMS-1:0]          txEn,
  output logic [15:0]                 connRdWord,
  output logic [7:0]                  dataRdByte
);

  localparam int ST_W = $clog2(STREAMS);
  localparam int CH_W = $clog2(CHANNELS);

  logic [15:0] connMem [STREAMS][CHANNELS];
  logic [7:0]  dataMem [2][STREAMS][CHANNELS];

  logic [STREAMS-1:0][7:0] outByte;
  logic [STREAMS-1:0][7:0] newByte;
  logic [STREAMS-1:0]      txBit;
  logic [STREAMS-1:0]      inBit;
  logic [STREAMS-1:0]      chanEn;

  // output selection, enables and loopback input choice
  always_comb begin
    for (int s = 0; s < STREAMS; s++) begin
      if (connMem[s][chan][BIT_PROC])
        outByte[s] = connMem[s][chan][7:0];
      else
        outByte[s] = dataMem[~strobe.bank][connMem[s][chan][CH_W +: ST_W]]
                            [connMem[s][chan][CH_W-1:0]];
      txBit[s]  = outByte[s][~bitIdx];
      chanEn[s] = strobe.globalEn && connMem[s][chan][BIT_OE];
      inBit[s]  = connMem[s][chan][BIT_LOOP] ? txBit[s] : rxIn[s];
    end
  end

  assign txData = txBit & chanEn;
  assign txEn   = chanEn;

  // per-stream deserializers
  for (genvar g = 0; g < STREAMS; g++) begin : gStream
    logic [6:0] shifter;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                shifter <= '0;
      else if (strobe.sampleBit) shifter <= {shifter[5:0], inBit[g]};
    end
    assign newByte[g] = {shifter, inBit[g]};
  end

  // data memory, written into the current bank
  always_ff @(posedge clk) begin
    if (strobe.byteDone) begin
      for (int s = 0; s < STREAMS; s++)
        dataMem[strobe.bank][s][chan] <= newByte[s];
    end
  end

  // connection memory
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < STREAMS; s++)
        for (int c = 0; c < CHANNELS; c++)
          connMem[s][c] <= '0;
    end else if (strobe.connWr) begin
      connMem[hostStream][hostChan] <= hostWrData;
    end
  end

  assign connRdWord = connMem[hostStream][hostChan];
  assign dataRdByte = dataMem[~strobe.bank][hostStream][hostChan];

endmodule

// File: rtl/tsi_core.sv
module tsi_core
  import tsi_pkg::*;
#(
  parameter int STREAMS      = 4,
  parameter int CHANNELS     = 32,
  parameter int CLKS_PER_BIT = 2
) (
  input  logic                                          clk,
  input  logic                                          rstN,
  input  logic                                          framePulse,
  input  logic                                          outDriveEn,
  input  logic [STREAMS-1:0]                            rxIn,
  output logic [STREAMS-1:0]                            txData,
  output logic [STREAMS-1:0]                            txEn,
  input  logic                                          hostWr,
  input  logic [2+$clog2(STREAMS)+$clog2(CHANNELS)-1:0] hostAddr,
  input  logic [15:0]                                   hostWrData,
  output logic [15:0]                                   hostRdData
);

  localparam int ST_W = $clog2(STREAMS);
  localparam int CH_W = $clog2(CHANNELS);

  tsiStrobe_t      strobe;
  logic [CH_W-1:0] chan;
  logic [2:0]      bitIdx;
  logic [ST_W-1:0] hostStream;
  logic [CH_W-1:0] hostChan;
  logic [15:0]     connRdWord;
  logic [7:0]      dataRdByte;

  tsi_ctrl #(
    .STREAMS(STREAMS), .CHANNELS(CHANNELS), .CLKS_PER_BIT(CLKS_PER_BIT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .framePulse(framePulse), .outDriveEn(outDriveEn),
    .hostWr(hostWr), .hostAddr(hostAddr), .standbyWrBit(hostWrData[0]),
    .connRdWord(connRdWord), .dataRdByte(dataRdByte), .strobe(strobe),
    .chan(chan), .bitIdx(bitIdx), .hostStream(hostStream), .hostChan(hostChan),
    .hostRdData(hostRdData)
  );

  tsi_datapath #(
    .STREAMS(STREAMS), .CHANNELS(CHANNELS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .chan(chan), .bitIdx(bitIdx),
    .hostStream(hostStream), .hostChan(hostChan), .hostWrData(hostWrData),
    .rxIn(rxIn), .txData(txData), .txEn(txEn), .connRdWord(connRdWord),
    .dataRdByte(dataRdByte)
  );

endmodule

// File: rtl/tsi_core_chk.sv
module tsi_core_chk #(
  parameter int STREAMS  = 4,
  parameter int CHANNELS = 32
) (
  input logic                                          clk,
  input logic                                          rstN,
  input logic                                          outDriveEn,
  input logic [STREAMS-1:0]                            txEn,
  input logic                                          hostWr,
  input logic [2+$clog2(STREAMS)+$clog2(CHANNELS)-1:0] hostAddr,
  input logic [15:0]                                   hostWrData,
  input logic [15:0]                                   hostRdData
);

  localparam int ADDR_W = 2 + $clog2(STREAMS) + $clog2(CHANNELS);

  logic [1:0] region;
  assign region = hostAddr[ADDR_W-1 -: 2];

  AST_RESET_HIZ: assert property (@(posedge clk)
    !rstN |=> (txEn == '0)); // R1

  AST_DRIVE_MASTER: assert property (@(posedge clk) disable iff (!rstN)
    !outDriveEn |-> (txEn == '0)); // R7

  AST_STANDBY_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && region == 2'd0 && !hostWrData[0]) |=> (txEn == '0)); // R8

  AST_CONN_READBACK: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && region == 2'd1) |=>
      ((hostAddr != $past(hostAddr)) || (hostRdData == $past(hostWrData)))); // R10

endmodule

bind tsi_core tsi_core_chk #(.STREAMS(STREAMS), .CHANNELS(CHANNELS)) u_chk (
  .clk(clk), .rstN(rstN), .outDriveEn(outDriveEn), .txEn(txEn),
  .hostWr(hostWr), .hostAddr(hostAddr), .hostWrData(hostWrData),
  .hostRdData(hostRdData)
);

// File: tb/tsi_core_tb.sv
module tsi_core_tb;

  localparam int S      = 4;
  localparam int C      = 32;
  localparam int CPB    = 2;
  localparam int ADDR_W = 2 + 2 + 5;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              framePulse = 1'b0;
  logic              outDriveEn = 1'b1;
  logic [S-1:0]      rxIn = '0;
  logic [S-1:0]      txData;
  logic [S-1:0]      txEn;
  logic              hostWr = 1'b0;
  logic [ADDR_W-1:0] hostAddr = '0;
  logic [15:0]       hostWrData = '0;
  logic [15:0]       hostRdData;

  int checks = 0;
  int fails  = 0;

  logic [15:0] connW [S][C];
  logic [7:0]  rxA   [S][C];
  logic [7:0]  rxB   [S][C];
  logic [7:0]  cap   [S][C];
  logic        enCap [S][C];
  logic        standbyM = 1'b0;

  always #10 clk = ~clk;

  tsi_core #(.STREAMS(S), .CHANNELS(C), .CLKS_PER_BIT(CPB)) u_dut (
    .clk(clk), .rstN(rstN), .framePulse(framePulse), .outDriveEn(outDriveEn),
    .rxIn(rxIn), .txData(txData), .txEn(txEn), .hostWr(hostWr),
    .hostAddr(hostAddr), .hostWrData(hostWrData), .hostRdData(hostRdData)
  );

  task automatic checkVal(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [1:0] rg, input int s, input int c, input logic [15:0] d);
    @(negedge clk);
    hostWr = 1'b1; hostAddr = {rg, 2'(s), 5'(c)}; hostWrData = d;
    if (rg == 2'd1) connW[s][c] = d;
    if (rg == 2'd0) standbyM = d[0];
    @(negedge clk);
    hostWr = 1'b0;
  endtask

  task automatic hostRead(input logic [1:0] rg, input int s, input int c, output logic [15:0] d);
    hostAddr = {rg, 2'(s), 5'(c)};
    #1;
    d = hostRdData;
  endtask

  task automatic fillPatterns(input int seed);
    for (int s = 0; s < S; s++)
      for (int c = 0; c < C; c++) begin
        rxA[s][c] = 8'((s * 67 + c * 13 + seed * 29) ^ (c << 3));
        rxB[s][c] = 8'((s * 41 + c * 7 + seed * 53) ^ 8'h96);
      end
  endtask

  // pulse, frame A (drives rxA), frame B (drives rxB, captured)
  task automatic runPair();
    @(negedge clk);
    framePulse = 1'b1;
    for (int f = 0; f < 2; f++)
      for (int c = 0; c < C; c++)
        for (int b = 0; b < 8; b++)
          for (int p = 0; p < CPB; p++) begin
            @(negedge clk);
            framePulse = (c == C - 1 && b == 7 && p == CPB - 1);
            for (int s = 0; s < S; s++) begin
              rxIn[s] = (f == 0) ? rxA[s][c][7-b] : rxB[s][c][7-b];
              if (f == 1 && p == 0) begin
                cap[s][c][7-b] = txData[s];
                if (b == 0) enCap[s][c] = txEn[s];
              end
            end
          end
    @(negedge clk);
    framePulse = 1'b0;
  endtask

  function automatic logic [7:0] effIn(input int s, input int c);
    if (connW[s][c][12]) return connW[s][c][7:0];
    return rxA[s][c];
  endfunction

  task automatic checkAll(input string tag);
    for (int s = 0; s < S; s++)
      for (int c = 0; c < C; c++) begin
        logic [15:0] w;
        logic        en;
        logic [7:0]  bv;
        w  = connW[s][c];
        en = standbyM && outDriveEn && w[13];
        bv = w[15] ? w[7:0] : effIn(int'(w[6:5]), int'(w[4:0]));
        checkVal($sformatf("%s out s%0d c%0d", tag, s, c),
                 {23'd0, enCap[s][c], cap[s][c]}, {23'd0, en, en ? bv : 8'd0});
      end
  endtask

  task automatic t_reset();
    logic [15:0] d;
    repeat (3) @(negedge clk);
    checkVal("R1 txEn in reset", 32'(txEn), 32'd0);
    hostRead(2'd0, 0, 0, d); checkVal("R1 ctrl reg", 32'(d), 32'd0);
    hostRead(2'd1, 1, 5, d); checkVal("R1 conn word", 32'(d), 32'd0);
    @(negedge clk); rstN = 1'b1;
    repeat (2) @(negedge clk);
    checkVal("R1 txEn after reset", 32'(txEn), 32'd0);
  endtask

  task automatic t_switch();
    hostWrite(2'd0, 0, 0, 16'h0001);
    for (int s = 0; s < S; s++)
      for (int c = 0; c < C; c++)
        hostWrite(2'd1, s, c, 16'h2000 | 16'(((s + 1) % S) << 5) | 16'((c * 5 + 3) % C));
    fillPatterns(1);
    runPair();
    checkAll("R2 R3");
  endtask

  task automatic t_broadcast();
    for (int c = 0; c < C; c++) hostWrite(2'd1, 0, c, 16'h2000 | 16'(2 << 5) | 16'd7);
    fillPatterns(2);
    repeat (37) @(negedge clk);
    runPair();
    checkAll("R4");
  endtask

  task automatic t_proc();
    hostWrite(2'd1, 3, 0,  16'hA000 | 16'(0 ^ 8'h5A));
    hostWrite(2'd1, 3, 9,  16'hA000 | 16'(9 ^ 8'h5A));
    hostWrite(2'd1, 3, 31, 16'hA000 | 16'(31 ^ 8'h5A));
    fillPatterns(3);
    runPair();
    checkAll("R5");
  endtask

  task automatic t_chanOe();
    hostWrite(2'd1, 2, 4,  connW[2][4]  & 16'hDFFF);
    hostWrite(2'd1, 2, 31, connW[2][31] & 16'hDFFF);
    fillPatterns(4);
    runPair();
    checkAll("R6");
  endtask

  task automatic t_loop();
    logic [15:0] d;
    hostWrite(2'd1, 1, 3, 16'hB0A5);
    hostWrite(2'd1, 0, 0, 16'h2023);
    fillPatterns(5);
    runPair();
    checkAll("R9");
    hostRead(2'd2, 1, 3, d); checkVal("R9 looped byte in data memory", 32'(d), 32'h00A5);
    hostRead(2'd2, 2, 6, d); checkVal("R10 data memory read", 32'(d), 32'(rxB[2][6]));
    hostWrite(2'd2, 2, 6, 16'h00FF);
    hostRead(2'd2, 2, 6, d); checkVal("R10 data memory write ignored", 32'(d), 32'(rxB[2][6]));
    hostRead(2'd1, 3, 9, d); checkVal("R10 conn readback", 32'(d), 32'(connW[3][9]));
    hostRead(2'd3, 1, 1, d); checkVal("R10 unused region", 32'(d), 32'd0);
    hostRead(2'd0, 0, 0, d); checkVal("R10 ctrl readback", 32'(d), 32'd1);
  endtask

  task automatic t_ode();
    outDriveEn = 1'b0;
    fillPatterns(6);
    runPair();
    checkAll("R7");
    outDriveEn = 1'b1;
  endtask

  task automatic t_standby();
    logic [15:0] d;
    hostWrite(2'd0, 0, 0, 16'hFFFE);
    hostRead(2'd0, 0, 0, d); checkVal("R8 standby readback", 32'(d), 32'd0);
    fillPatterns(7);
    runPair();
    checkAll("R8");
    hostWrite(2'd0, 0, 0, 16'h0001);
    fillPatterns(8);
    runPair();
    checkAll("R8 re-enabled");
  endtask

  initial begin
    for (int s = 0; s < S; s++)
      for (int c = 0; c < C; c++) connW[s][c] = '0;
    t_reset();
    t_switch();
    t_broadcast();
    t_proc();
    t_chanOe();
    t_loop();
    t_ode();
    t_standby();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule